// File: doc/BRIEF.md
# Telephony Tone Synthesizer

This block turns a frequency code and a gain code into a stream of signed 16-bit linear samples, one per sample strobe. The strobe is expected at 8 kHz. A mode input selects between two code tables. In dual-tone mode the code picks one row frequency and one column frequency from the standard 4x4 keypad matrix, and the two sine waves are summed. In signalling mode the code picks a steady single tone, a tone that alternates between two pitches, a 400 Hz tone that is keyed on and off, or silence.

Each tone component comes from a 16-bit phase accumulator. The top byte of the accumulator addresses a 256-entry sine ROM, which is filled with computed values when the block elaborates. The summed signal then goes through a 2 dB-step attenuation ladder, and the result leaves through a registered output with a one-cycle valid pulse. Companding, mixing with voice and any analog stage belong to neighbouring blocks.

Top module: `tone_synth`

## Requirements
- R1: While reset is held, and after it is released, `out_valid` is 0 and `out_sample` is 0 until the first strobe is processed.
- R2: Every cycle in which `sample_stb` is high produces exactly one `out_valid` pulse. The pulse comes three clock edges later, counting the edge that samples the strobe.
- R3: Each lane has a 16-bit phase accumulator that advances only on a strobe, by round(f*65536/8000). Sample k after a restart uses phase P_k, where P_0 = 0 and P_{k+1} = P_k + increment. The sine value is S(i) = round(16383*sin(2*pi*i/256)), rounded half away from zero, with i = P_k[15:8].
- R4: In dual-tone mode, code bits [3:2] select the row frequency (0:697, 1:770, 2:852, 3:941 Hz) and bits [1:0] select the column frequency (0:1209, 1:1336, 2:1477, 3:1633 Hz). Bit 4 is ignored: changing only bit 4 does not restart the phases.
- R5: In dual-tone mode the pre-gain sum is S(col) + floor(S(row)*W/32768), where W = round(32768*10^(-0.1)) = 26029. This keeps the row tone 2 dB below the column tone.
- R6: The output is floor(sum*G/32768), where G(c) = round(32768*10^((2c-36)/20)) for gain code c. This runs from -36 dB at c=0 up to -6 dB at c=15.
- R7: In signalling mode, codes 9 through 22 give steady tones of, in code order: 400, 425, 440, 450, 800, 1000, 1300, 2000, 2042, 2514, 500, 667, 1333 and 2100 Hz.
- R8: In signalling mode, codes 0 to 4 alternate between the pairs 1000/1333, 800/667, 800/1000, 500/667 and 500/400 Hz at a 16 Hz rate, holding each pitch for 250 samples. Codes 5 and 6 alternate 800/1000 and 500/400 Hz, holding each pitch for 500 samples. The first pitch is used first, and the accumulator is not reset at a switch.
- R9: In signalling mode, codes 7 and 8 run a 400 Hz tone that is audible for 250 (code 7) or 200 (code 8) samples and then zero for the same count, repeating. The phase keeps advancing while the output is zero.
- R10: In signalling mode, codes 23 to 31 produce zero samples.
- R11: While `enable` is low, a strobe yields a valid zero sample, and the accumulators and the alternation state are held cleared. The first strobe after `enable` rises uses phase 0 and the first pitch.
- R12: A strobe whose mode, or whose effective code, differs from the one seen at the previous strobe restarts the phases at 0 and the alternation at the first pitch. Changes that are undone before the next strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Tone generation enable; low clears the phase state |
| dual_mode | input | 1 | 1: keypad dual-tone table, 0: signalling table |
| freq_code | input | 5 | Tone selection code |
| gain_code | input | 4 | Attenuation step, -36 dB to -6 dB |
| sample_stb | input | 1 | One-cycle request for the next sample |
| out_sample | output | 16 | Signed linear sample |
| out_valid | output | 1 | One-cycle pulse marking a new sample |

## Verification
The embedded properties assume that `sample_stb` is low while reset is asserted. They also assume that the mode and code stay constant during a run of strobes on one tone, so that the alternation counter always compares against the hold count of the tone in progress. The bench drives the strobe only after reset and changes the mode, code, gain and enable only on the falling edge before a strobe. It spaces the strobes several cycles apart, so each sample is checked against an arithmetic model before the next one is requested.

// File: rtl/tone_pkg.sv
package tone_pkg;

  localparam int SAMPLE_RATE = 8000;
  localparam int ACC_W       = 16;
  localparam int CODE_W      = 5;
  localparam int GAIN_W      = 4;
  localparam int HOLD_W      = 10;
  localparam int KEY_W       = CODE_W + 1;
  localparam int COEF_W      = 16;

  // Row component weight: -2 dB in Q15
  localparam int ROW_WEIGHT = $rtoi(32768.0 * (10.0 ** (-0.1)) + 0.5);

  typedef struct packed {
    logic [ACC_W-1:0]  inc_a;
    logic [ACC_W-1:0]  inc_b;
    logic [HOLD_W-1:0] hold;
    logic              warble;
    logic              gated;
    logic              silent;
  } tone_plan_t;

  function automatic logic [ACC_W-1:0] hz_to_inc(input int hz);
    return ACC_W'((hz * (2 ** ACC_W) + SAMPLE_RATE / 2) / SAMPLE_RATE);
  endfunction

  function automatic logic [HOLD_W-1:0] half_period(input int rate_hz);
    return HOLD_W'(SAMPLE_RATE / (2 * rate_hz));
  endfunction

  function automatic tone_plan_t plan_silence();
    tone_plan_t p;
    p = '0;
    p.silent = 1'b1;
    return p;
  endfunction

  function automatic tone_plan_t plan_single(input int hz);
    tone_plan_t p;
    p = '0;
    p.inc_a = hz_to_inc(hz);
    p.inc_b = hz_to_inc(hz);
    return p;
  endfunction

  function automatic tone_plan_t plan_pair(input int hz_a, input int hz_b, input int rate_hz);
    tone_plan_t p;
    p = '0;
    p.inc_a  = hz_to_inc(hz_a);
    p.inc_b  = hz_to_inc(hz_b);
    p.hold   = half_period(rate_hz);
    p.warble = 1'b1;
    return p;
  endfunction

  function automatic tone_plan_t plan_keyed(input int hz, input int rate_hz);
    tone_plan_t p;
    p = plan_pair(hz, hz, rate_hz);
    p.gated = 1'b1;
    return p;
  endfunction

  function automatic logic [COEF_W-1:0] gain_coef(input int step);
    return COEF_W'($rtoi(32768.0 * (10.0 ** ((2.0 * step - 36.0) / 20.0)) + 0.5));
  endfunction

endpackage

// File: rtl/tone_plan_decode.sv
module tone_plan_decode
  import tone_pkg::*;
(
  input  logic              dual_mode,
  input  logic [CODE_W-1:0] code,
  output logic [ACC_W-1:0]  row_inc,
  output tone_plan_t        plan
);

  always_comb begin
    row_inc = '0;
    plan    = plan_silence();
    if (dual_mode) begin
      case (code[3:2])
        2'd0:    row_inc = hz_to_inc(697);
        2'd1:    row_inc = hz_to_inc(770);
        2'd2:    row_inc = hz_to_inc(852);
        default: row_inc = hz_to_inc(941);
      endcase
      case (code[1:0])
        2'd0:    plan = plan_single(1209);
        2'd1:    plan = plan_single(1336);
        2'd2:    plan = plan_single(1477);
        default: plan = plan_single(1633);
      endcase
    end else begin
      case (code)
        5'd0:    plan = plan_pair(1000, 1333, 16);
        5'd1:    plan = plan_pair(800, 667, 16);
        5'd2:    plan = plan_pair(800, 1000, 16);
        5'd3:    plan = plan_pair(500, 667, 16);
        5'd4:    plan = plan_pair(500, 400, 16);
        5'd5:    plan = plan_pair(800, 1000, 8);
        5'd6:    plan = plan_pair(500, 400, 8);
        5'd7:    plan = plan_keyed(400, 16);
        5'd8:    plan = plan_keyed(400, 20);
        5'd9:    plan = plan_single(400);
        5'd10:   plan = plan_single(425);
        5'd11:   plan = plan_single(440);
        5'd12:   plan = plan_single(450);
        5'd13:   plan = plan_single(800);
        5'd14:   plan = plan_single(1000);
        5'd15:   plan = plan_single(1300);
        5'd16:   plan = plan_single(2000);
        5'd17:   plan = plan_single(2042);
        5'd18:   plan = plan_single(2514);
        5'd19:   plan = plan_single(500);
        5'd20:   plan = plan_single(667);
        5'd21:   plan = plan_single(1333);
        5'd22:   plan = plan_single(2100);
        default: plan = plan_silence();
      endcase
    end
  end

endmodule

// File: rtl/tone_phase_lane.sv
module tone_phase_lane #(
  parameter int ACC_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              step,
  input  logic              restart,
  input  logic [ACC_W-1:0]  inc,
  output logic [ADDR_W-1:0] rd_addr
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] base;

  assign base    = restart ? '0 : acc_q;
  assign rd_addr = base[ACC_W-1 -: ADDR_W];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_q <= '0;
    end else if (step) begin
      acc_q <= base + inc;
    end
  end

  AST_LANE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clear |=> acc_q == '0); // R11
  AST_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step && !clear) |=> $stable(acc_q)); // R3
  AST_LANE_RESTART: assert property (@(posedge clk) disable iff (rst)
    (step && restart && !clear) |=> acc_q == $past(inc)); // R12

endmodule

// File: rtl/tone_sine_rom.sv
module tone_sine_rom #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int AMP    = 16383
) (
  input  logic                     clk,
  input  logic [ADDR_W-1:0]        addr,
  output logic signed [DATA_W-1:0] data
);

  localparam int  DEPTH = 1 << ADDR_W;
  localparam real TWO_PI = 6.283185307179586;

  logic signed [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin : fill
      real x;
      x = AMP * $sin(TWO_PI * i / DEPTH);
      if (x >= 0.0) mem[i] = DATA_W'($rtoi(x + 0.5));
      else          mem[i] = DATA_W'(-$rtoi(0.5 - x));
    end
  end

  always_ff @(posedge clk) begin
    data <= mem[addr];
  end

endmodule

// File: rtl/tone_synth.sv
module tone_synth
  import tone_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int AMP    = 16383
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              dual_mode,
  input  logic [4:0]        freq_code,
  input  logic [3:0]        gain_code,
  input  logic              sample_stb,
  output logic [DATA_W-1:0] out_sample,
  output logic              out_valid
);

  localparam int LANES  = 2;          // 0: row/unused, 1: column/main
  localparam int SUM_W  = DATA_W + 1;
  localparam int FRAC   = 15;
  localparam int STEPS  = 1 << GAIN_W;
  localparam logic [COEF_W-1:0] ROW_W_Q = COEF_W'(ROW_WEIGHT);

  // ---------------- tone selection and restart detection
  logic [KEY_W-1:0] key_d, key_q;
  logic             restart;
  tone_plan_t       plan;
  logic [ACC_W-1:0] row_inc;

  assign key_d   = {dual_mode, dual_mode ? 1'b0 : freq_code[CODE_W-1], freq_code[CODE_W-2:0]};
  assign restart = (key_d != key_q);

  tone_plan_decode u_decode (
    .dual_mode (dual_mode),
    .code      (freq_code),
    .row_inc   (row_inc),
    .plan      (plan)
  );

  // ---------------- alternation sequencer
  logic [HOLD_W-1:0] cnt_q, cur_cnt;
  logic              half_q, cur_half;
  logic              step;

  assign step     = sample_stb & enable;
  assign cur_half = restart ? 1'b0 : half_q;
  assign cur_cnt  = restart ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q  <= '0;
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (!enable) begin
      key_q  <= key_d;
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else if (sample_stb) begin
      key_q <= key_d;
      if (plan.warble) begin
        if (cur_cnt == plan.hold - 1'b1) begin
          cnt_q  <= '0;
          half_q <= ~cur_half;
        end else begin
          cnt_q  <= cur_cnt + 1'b1;
          half_q <= cur_half;
        end
      end else begin
        cnt_q  <= '0;
        half_q <= 1'b0;
      end
    end
  end

  // ---------------- phase lanes and sine ROMs
  logic [ACC_W-1:0]         lane_inc  [LANES];
  logic signed [DATA_W-1:0] lane_sine [LANES];

  assign lane_inc[0] = dual_mode ? row_inc : '0;
  assign lane_inc[1] = cur_half ? plan.inc_b : plan.inc_a;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ADDR_W-1:0] addr;

    tone_phase_lane #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .clear   (~enable),
      .step    (step),
      .restart (restart),
      .inc     (lane_inc[l]),
      .rd_addr (addr)
    );

    tone_sine_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .AMP(AMP)) u_rom (
      .clk  (clk),
      .addr (addr),
      .data (lane_sine[l])
    );
  end

  // ---------------- gain ladder
  logic [COEF_W-1:0] gain_lut [STEPS];
  for (genvar c = 0; c < STEPS; c++) begin : g_gain
    localparam logic [COEF_W-1:0] COEF = gain_coef(c);
    assign gain_lut[c] = COEF;
  end

  // ---------------- pipeline stage 1 (aligned with ROM read)
  logic              v1, z1, d1;
  logic [GAIN_W-1:0] g1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      z1 <= 1'b1;
      d1 <= 1'b0;
      g1 <= '0;
    end else begin
      v1 <= sample_stb;
      z1 <= ~enable | (~dual_mode & (plan.silent | (plan.gated & cur_half)));
      d1 <= dual_mode;
      g1 <= gain_code;
    end
  end

  // ---------------- pipeline stage 2: weighted sum
  logic signed [2*DATA_W:0] row_prod;
  logic signed [SUM_W-1:0]  row_part, col_part, sum_d, sum_q;
  logic                     v2;
  logic [GAIN_W-1:0]        g2;

  assign row_prod = lane_sine[0] * $signed({1'b0, ROW_W_Q});
  assign row_part = SUM_W'(row_prod >>> FRAC);
  assign col_part = SUM_W'(lane_sine[1]);

  always_comb begin
    if (z1)      sum_d = '0;
    else if (d1) sum_d = col_part + row_part;
    else         sum_d = col_part;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      v2    <= 1'b0;
      g2    <= '0;
    end else begin
      sum_q <= sum_d;
      v2    <= v1;
      g2    <= g1;
    end
  end

  // ---------------- pipeline stage 3: attenuation and output register
  logic signed [SUM_W+COEF_W:0] gain_prod;
  assign gain_prod = sum_q * $signed({1'b0, gain_lut[g2]});

  always_ff @(posedge clk) begin
    if (rst) begin
      out_sample <= '0;
      out_valid  <= 1'b0;
    end else begin
      out_sample <= DATA_W'(gain_prod >>> FRAC);
      out_valid  <= v2;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(sample_stb, 3)); // R2
  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(!enable, 3)) |-> out_sample == '0); // R11
  AST_SILENT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(!dual_mode && freq_code >= 5'd23, 3)) |-> out_sample == '0); // R10
  AST_WARBLE_BOUND: assert property (@(posedge clk) disable iff (rst)
    (enable && !restart && plan.warble) |-> cnt_q < plan.hold); // R8

endmodule

// File: tb/tone_synth_test.sv
module tone_synth_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        dual_mode = 1'b0;
  logic [4:0]  freq_code = '0;
  logic [3:0]  gain_code = '0;
  logic        sample_stb = 1'b0;
  logic [15:0] out_sample;
  logic        out_valid;

  int errors = 0;
  int checks = 0;

  tone_synth uut (
    .clk(clk), .rst(rst), .enable(enable), .dual_mode(dual_mode),
    .freq_code(freq_code), .gain_code(gain_code), .sample_stb(sample_stb),
    .out_sample(out_sample), .out_valid(out_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference tables from the requirements
  int row_hz [4] = '{697, 770, 852, 941};
  int col_hz [4] = '{1209, 1336, 1477, 1633};
  int sig_a [32];
  int sig_b [32];
  int sig_hold [32];
  bit sig_gate [32];
  bit sig_sil [32];

  task automatic set_sig(int c, int a, int b, int hold, bit gate, bit sil);
    sig_a[c] = a; sig_b[c] = b; sig_hold[c] = hold; sig_gate[c] = gate; sig_sil[c] = sil;
  endtask

  task automatic init_tables();
    int singles [14] = '{400, 425, 440, 450, 800, 1000, 1300, 2000, 2042, 2514, 500, 667, 1333, 2100};
    set_sig(0, 1000, 1333, 250, 0, 0);
    set_sig(1, 800, 667, 250, 0, 0);
    set_sig(2, 800, 1000, 250, 0, 0);
    set_sig(3, 500, 667, 250, 0, 0);
    set_sig(4, 500, 400, 250, 0, 0);
    set_sig(5, 800, 1000, 500, 0, 0);
    set_sig(6, 500, 400, 500, 0, 0);
    set_sig(7, 400, 400, 250, 1, 0);
    set_sig(8, 400, 400, 200, 1, 0);
    for (int i = 0; i < 14; i++) set_sig(9 + i, singles[i], singles[i], 0, 0, 0);
    for (int i = 23; i < 32; i++) set_sig(i, 0, 0, 0, 0, 1);
  endtask

  function automatic int inc_of(int hz);
    return (hz * 65536 + 4000) / 8000;
  endfunction

  function automatic int sine_of(int idx);
    real x;
    x = 16383.0 * $sin(6.283185307179586 * idx / 256.0);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(0.5 - x);
  endfunction

  function automatic int gain_of(int c);
    return $rtoi(32768.0 * $pow(10.0, (2.0 * c - 36.0) / 20.0) + 0.5);
  endfunction

  int row_w;

  // ---------------- reference model state
  int m_ph [2] = '{0, 0};
  int m_cnt = 0;
  bit m_half = 0;
  int m_key = 0;

  task automatic model_step(output int expv);
    int key, lo_inc, hi_inc, sum, c;
    bit zero;
    c = int'(freq_code);
    key = dual_mode ? (32 + (c & 15)) : c;
    if (!enable) begin
      expv = 0; m_ph[0] = 0; m_ph[1] = 0; m_cnt = 0; m_half = 0; m_key = key;
      return;
    end
    if (key != m_key) begin
      m_ph[0] = 0; m_ph[1] = 0; m_cnt = 0; m_half = 0;
    end
    if (dual_mode) begin
      lo_inc = inc_of(row_hz[(c >> 2) & 3]);
      hi_inc = inc_of(col_hz[c & 3]);
      sum = sine_of(m_ph[1] >> 8) + ((sine_of(m_ph[0] >> 8) * row_w) >>> 15);
      zero = 0;
    end else begin
      lo_inc = 0;
      hi_inc = inc_of(m_half ? sig_b[c] : sig_a[c]);
      sum = sine_of(m_ph[1] >> 8);
      zero = sig_sil[c] || (sig_gate[c] && m_half);
    end
    if (zero) sum = 0;
    expv = (sum * gain_of(int'(gain_code))) >>> 15;
    m_ph[0] = (m_ph[0] + lo_inc) & 65535;
    m_ph[1] = (m_ph[1] + hi_inc) & 65535;
    if (!dual_mode && sig_hold[c] > 0) begin
      m_cnt++;
      if (m_cnt == sig_hold[c]) begin
        m_cnt = 0;
        m_half = !m_half;
      end
    end
    m_key = key;
  endtask

  // ---------------- one strobe, latency and value check
  task automatic strobe_check(string tag);
    int expv, lat, act;
    model_step(expv);
    @(negedge clk) sample_stb = 1'b1;
    @(negedge clk) sample_stb = 1'b0;
    lat = 0;
    while (!out_valid && lat < 6) begin
      @(negedge clk);
      lat++;
    end
    checks++;
    if (lat != 2) begin
      errors++;
      $display("FAIL R2 valid latency: got %0d expected 2", lat);
    end
    act = int'($signed(out_sample));
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s code=%0d dual=%0d gain=%0d: got %0d expected %0d",
               tag, freq_code, dual_mode, gain_code, act, expv);
    end
  endtask

  task automatic run(string tag, int n);
    for (int i = 0; i < n; i++) strobe_check(tag);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    init_tables();
    row_w = $rtoi(32768.0 * $pow(10.0, -0.1) + 0.5);
    repeat (4) @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || out_sample !== 16'd0) begin
      errors++;
      $display("FAIL R1 during reset: got %0d/%0d expected 0/0", out_valid, out_sample);
    end
    rst = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_sample !== 16'd0) begin
      errors++;
      $display("FAIL R1 after reset: got %0d/%0d expected 0/0", out_valid, out_sample);
    end

    enable = 1'b1;
    // R3: plain single tone at top gain
    dual_mode = 1'b0; freq_code = 5'd14; gain_code = 4'd15;
    run("R3 single 1000 Hz", 40);

    // R4 / R5: every keypad code
    dual_mode = 1'b1;
    for (int c = 0; c < 16; c++) begin
      freq_code = 5'(c);
      run("R5 keypad pair", 24);
    end
    // R4: bit 4 ignored, phase continues
    freq_code = 5'd5;
    run("R4 keypad", 10);
    freq_code = 5'd21;
    run("R4 bit4 ignored", 10);

    // R6: whole gain ladder
    freq_code = 5'd0;
    for (int g = 0; g < 16; g++) begin
      gain_code = 4'(g);
      run("R6 gain ladder", 8);
    end

    // R7: steady tones
    dual_mode = 1'b0; gain_code = 4'd12;
    for (int c = 9; c < 23; c++) begin
      freq_code = 5'(c);
      run("R7 single tone", 40);
    end
    // R8: alternating pairs
    gain_code = 4'd15;
    for (int c = 0; c < 7; c++) begin
      freq_code = 5'(c);
      run("R8 warble pair", 600);
    end
    // R9: keyed 400 Hz
    for (int c = 7; c < 9; c++) begin
      freq_code = 5'(c);
      run("R9 keyed tone", 520);
    end
    // R10: silence codes
    for (int c = 23; c < 32; c++) begin
      freq_code = 5'(c);
      run("R10 silence", 5);
    end

    // R12: restart on code change mid-alternation, and undone change
    freq_code = 5'd0;
    run("R12 before change", 100);
    freq_code = 5'd2;
    run("R12 restart", 30);
    freq_code = 5'd5;
    @(negedge clk);
    freq_code = 5'd2;
    run("R12 undone change", 30);
    dual_mode = 1'b1; freq_code = 5'd2;
    run("R12 mode change", 20);

    // R11: disable clears, re-enable starts from phase 0
    dual_mode = 1'b0; freq_code = 5'd1;
    run("R11 before disable", 300);
    enable = 1'b0;
    run("R11 disabled zero", 5);
    enable = 1'b1;
    run("R11 re-enabled", 260);

    finish_run();
  end

endmodule